// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that a processor arms and then services through three 32-bit registers: a count register, a control register and an auxiliary register. Every write has to carry a fixed key in its upper bits, so a stray store does not silently disarm the timer or move its count. Once it is enabled, a 16-bit up-counter advances on ticks from a prescaler with eight settings. When the counter wraps past its top value, the block latches an overflow flag and raises a one-cycle reset request toward the chip's reset logic.

Software sets a timeout of N ticks by loading 65536 minus N into the counter. A value written to the count register does not reach the counter at once. It sits in a holding stage for two clock cycles, and a pending flag in the control register shows that the transfer is still in progress. Software is expected to stop the timer before it reloads the count or changes the prescaler, and to poll the pending flag before it issues another count write.

Top module: `kwdt_top`

## Requirements
- R1: After reset, every register reads zero and the reset request is low.
- R2: A write to the control register (word 1) is accepted only when bits 31:8 equal 0xA5A5A5. An accepted write takes bit 7 as the run enable and bits 2:0 as the prescale select. A write with any other key changes nothing.
- R3: A write to the count register (word 0) is accepted only when bits 31:16 equal 0x5A5A, with the count in bits 15:0. A write with any other key neither changes the count nor raises the pending flag.
- R4: An accepted count write sets control bit 5 (pending), which reads 1 for exactly two cycles. In the cycle the flag clears, the count register shows the new value.
- R5: A count write that arrives while the pending flag is set is dropped: the value already in transfer is the one that lands.
- R6: While the run enable is 0, the count holds its value.
- R7: While the run enable is 1, the count advances once every D cycles, where D is 1, 4, 16, 32, 64, 128, 1024 or 4096 for select codes 0 through 7. The first advance comes D cycles after the enabling write.
- R8: When a tick moves the count from 0xFFFF to 0, control bit 4 (overflow) is set and the reset request is high for exactly one cycle.
- R9: The overflow flag stays set until an accepted control write carries 0 in bit 4. Writing 1 to bit 4, or using a wrong key, leaves the flag unchanged.
- R10: The auxiliary register (word 2) stores bits 7:0 of a write whose bits 31:8 equal 0xA5A5A5, ignores writes with any other key, and has no effect on counting.
- R11: Reads return zero in all key and unused bit positions. Word 3 reads zero. Control bit 5 cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 2 | Word index of the write |
| wr_data | input | 32 | Write data, key in the upper bits |
| rd_addr | input | 2 | Word index of the read |
| rd_data | output | 32 | Read data (combinational) |
| rst_req | output | 1 | One-cycle reset request on counter wrap |

## Verification
The hardest situation to reach from the ports is a second count write that lands while the first is still in its two-cycle transfer. A port-level write takes a whole cycle, so the stimulus issues two writes back to back and checks that the first value is the one that lands and stays. The wrap event is reached without 65536 ticks of waiting: the counter is loaded with 0xFFFE while stopped, then run at divisor 1, and the flag and the one-cycle reset pulse are sampled on the exact cycles of the wrap. The two largest divisors are covered by sampling one cycle before and one cycle after the second tick.

// File: rtl/kwdt_pkg.sv
// Package: shared constants, register word indices and the prescale
// table for the key-protected watchdog.
// Assumes a 32-bit register interface with word addressing.
package kwdt_pkg;

    typedef enum logic [1:0] {
        ADDR_CNT  = 2'd0,
        ADDR_CTRL = 2'd1,
        ADDR_AUX  = 2'd2,
        ADDR_NONE = 2'd3
    } kwdt_addr_e;

    localparam logic [23:0] KEY_CTRL = 24'hA5A5A5;
    localparam logic [15:0] KEY_CNT  = 16'h5A5A;

    localparam int BIT_RUN  = 7;
    localparam int BIT_PEND = 5;
    localparam int BIT_OVF  = 4;

    localparam int PRE_W = 12;

    // Terminal count (divisor minus one) of the prescaler for a select code.
    function automatic logic [PRE_W-1:0] term_of(input logic [2:0] sel);
        logic [PRE_W-1:0] t;
        case (sel)
            3'd0:    t = PRE_W'(0);
            3'd1:    t = PRE_W'(3);
            3'd2:    t = PRE_W'(15);
            3'd3:    t = PRE_W'(31);
            3'd4:    t = PRE_W'(63);
            3'd5:    t = PRE_W'(127);
            3'd6:    t = PRE_W'(1023);
            default: t = PRE_W'(4095);
        endcase
        return t;
    endfunction

endpackage

// File: rtl/kwdt_regif.sv
// Module: kwdt_regif
// Checks write keys and holds the control fields (run enable, prescale
// select, overflow flag) and the auxiliary byte. A count write with a valid
// key is passed on as a one-cycle strobe. Assumes that overflow set wins
// over a software clear in the same cycle.
module kwdt_regif
    import kwdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ovf_set,
    output logic              run,
    output logic [2:0]        sel,
    output logic              ovf,
    output logic [7:0]        aux,
    output logic              cnt_wr,
    output logic [CNT_W-1:0]  cnt_wdata
);

    localparam int CK_LO = DATA_W - 24;
    localparam int NK_LO = DATA_W - 16;

    logic ctrl_ok;
    logic aux_ok;

    // Decode key-valid writes per word.
    always_comb begin
        ctrl_ok   = wr_en && (wr_addr == ADDR_CTRL) && (wr_data[DATA_W-1:CK_LO] == KEY_CTRL);
        aux_ok    = wr_en && (wr_addr == ADDR_AUX)  && (wr_data[DATA_W-1:CK_LO] == KEY_CTRL);
        cnt_wr    = wr_en && (wr_addr == ADDR_CNT)  && (wr_data[DATA_W-1:NK_LO] == KEY_CNT);
        cnt_wdata = wr_data[CNT_W-1:0];
    end

    // Control fields: enable and select from an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            sel <= 3'd0;
        end else if (ctrl_ok) begin
            run <= wr_data[BIT_RUN];
            sel <= wr_data[2:0];
        end
    end

    // Overflow flag: set by the counter wrap, cleared by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (ovf_set) begin
            ovf <= 1'b1;
        end else if (ctrl_ok && !wr_data[BIT_OVF]) begin
            ovf <= 1'b0;
        end
    end

    // Auxiliary byte: plain storage behind the control key.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aux <= 8'd0;
        end else if (aux_ok) begin
            aux <= wr_data[7:0];
        end
    end

    p_bad_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_CTRL && wr_data[DATA_W-1:CK_LO] != KEY_CTRL)
        |=> ($stable(run) && $stable(sel)));

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ctrl_ok) |=> ovf);

    p_aux_key_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_AUX && wr_data[DATA_W-1:CK_LO] != KEY_CTRL)
        |=> $stable(aux));

endmodule

// File: rtl/kwdt_prescaler.sv
// Module: kwdt_prescaler
// Divides the clock into count ticks. The phase counter is held at zero
// while the timer is stopped, so the first tick comes a full period after
// the enable. Assumes the select is not changed while the timer runs.
module kwdt_prescaler
    import kwdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [2:0]       sel,
    output logic             tick
);

    logic [PRE_W-1:0] phase;
    logic [PRE_W-1:0] term;

    // Look up the terminal phase and raise the tick on it.
    always_comb begin
        term = term_of(sel);
        tick = run && (phase >= term);
    end

    // Phase counter: wraps at the terminal, cleared while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase <= '0;
        end else if (phase >= term) begin
            phase <= '0;
        end else begin
            phase <= phase + PRE_W'(1);
        end
    end

    p_phase_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (phase == '0));

endmodule

// File: rtl/kwdt_counter.sv
// Module: kwdt_counter
// Holds the 16-bit up-counter, the holding stage for written values and the
// pending flag, and produces the wrap event and the registered reset pulse.
// A load that completes takes priority over a tick in the same cycle.
module kwdt_counter #(
    parameter int CNT_W    = 16,
    parameter int SYNC_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] count,
    output logic             pend,
    output logic             wrap,
    output logic             rst_req
);

    localparam int SW = $clog2(SYNC_CYC + 1);

    logic [CNT_W-1:0] staged;
    logic [SW-1:0]    left;
    logic             load_now;

    // Load strobe on the last transfer cycle; wrap on a tick at the top value.
    always_comb begin
        load_now = pend && (left == SW'(1));
        wrap     = tick && !load_now && (count == {CNT_W{1'b1}});
    end

    // Holding stage: capture a write when idle, count down the transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged <= '0;
            left   <= '0;
            pend   <= 1'b0;
        end else if (cnt_wr && !pend) begin
            staged <= cnt_wdata;
            left   <= SW'(SYNC_CYC);
            pend   <= 1'b1;
        end else if (pend) begin
            left <= left - SW'(1);
            if (left == SW'(1)) begin
                pend <= 1'b0;
            end
        end
    end

    // Counter: take the transferred value, else advance on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load_now) begin
            count <= staged;
        end else if (tick) begin
            count <= count + CNT_W'(1);
        end
    end

    // Reset request: one registered pulse per wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
        end else begin
            rst_req <= wrap;
        end
    end

    p_pend_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |=> pend);

    p_pend_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && left == SW'(1)) |=> (!pend && count == $past(staged)));

    p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && cnt_wr) |=> $stable(staged));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_now) |=> $stable(count));

    p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    p_wrap_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (count == '0));

endmodule

// File: rtl/kwdt_top.sv
// Module: kwdt_top
// Key-protected watchdog: the register interface, the prescaler and the
// counter, plus the read multiplexer. Reads are combinational and return
// zero in key and unused positions. Assumes one clock for the whole block.
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 16,
    parameter int SYNC_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rst_req
);

    logic             run;
    logic [2:0]       sel;
    logic             ovf;
    logic [7:0]       aux;
    logic             cnt_wr;
    logic [CNT_W-1:0] cnt_wdata;
    logic             tick;
    logic [CNT_W-1:0] count;
    logic             pend;
    logic             wrap;

    kwdt_regif #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ovf_set   (wrap),
        .run       (run),
        .sel       (sel),
        .ovf       (ovf),
        .aux       (aux),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata)
    );

    kwdt_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .sel   (sel),
        .tick  (tick)
    );

    kwdt_counter #(.CNT_W(CNT_W), .SYNC_CYC(SYNC_CYC)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .count     (count),
        .pend      (pend),
        .wrap      (wrap),
        .rst_req   (rst_req)
    );

    // Read multiplexer: assemble each word with zero padding.
    always_comb begin
        case (rd_addr)
            ADDR_CNT:  rd_data = {{(DATA_W-CNT_W){1'b0}}, count};
            ADDR_CTRL: rd_data = {{(DATA_W-8){1'b0}}, run, 1'b0, pend, ovf, 1'b0, sel};
            ADDR_AUX:  rd_data = {{(DATA_W-8){1'b0}}, aux};
            default:   rd_data = '0;
        endcase
    end

    p_flag_with_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ovf);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!rst_req && !pend));

endmodule

// File: tb/kwdt_top_tb.sv
module kwdt_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [31:0] rd_data;
    logic        rst_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam logic [31:0] KC = 32'hA5A5A500;
    localparam logic [31:0] KN = 32'h5A5A0000;

    always #5 clk = ~clk;

    kwdt_top u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .rst_req (rst_req)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h exp %h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // Issue one write; starts and ends at a falling edge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input logic [15:0] v);
        wr(2'd0, KN | 32'(v));
        repeat (2) @(negedge clk);
    endtask

    function automatic int div_of(input int c);
        case (c)
            0: return 1;
            1: return 4;
            2: return 16;
            3: return 32;
            4: return 64;
            5: return 128;
            6: return 1024;
            default: return 4096;
        endcase
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk("R1 reset read", d, 32'd0);
        end
        chk("R1 reset rst_req", 32'(rst_req), 32'd0);
    endtask

    task automatic t_ctrl_key();
        logic [31:0] d;
        wr(2'd1, 32'h12345685);
        rd(2'd1, d);
        chk("R2 bad key ignored", d, 32'h0);
        wr(2'd1, KC | 32'h05);
        rd(2'd1, d);
        chk("R2 select stored", d, 32'h05);
        wr(2'd1, KC | 32'h25);
        rd(2'd1, d);
        chk("R11 pend bit not writable", d, 32'h05);
        wr(2'd1, KC);
        rd(2'd1, d);
        chk("R2 cleared", d, 32'h0);
        rd(2'd3, d);
        chk("R11 word 3 zero", d, 32'h0);
    endtask

    task automatic t_cnt_key();
        logic [31:0] d;
        wr(2'd0, 32'h12341234);
        rd(2'd1, d);
        chk("R3 bad key no pend", d, 32'h0);
        repeat (3) @(negedge clk);
        rd(2'd0, d);
        chk("R3 bad key no load", d, 32'h0);
        wr(2'd0, KN | 32'hBEEF);
        rd(2'd1, d);
        chk("R4 pend first cycle", d, 32'h20);
        @(negedge clk);
        rd(2'd1, d);
        chk("R4 pend second cycle", d, 32'h20);
        @(negedge clk);
        rd(2'd1, d);
        chk("R4 pend cleared", d, 32'h0);
        rd(2'd0, d);
        chk("R3 R11 value landed", d, 32'h0000BEEF);
    endtask

    task automatic t_drop();
        logic [31:0] d;
        wr(2'd0, KN | 32'h1234);
        wr(2'd0, KN | 32'h5678);
        @(negedge clk);
        rd(2'd0, d);
        chk("R5 first value lands", d, 32'h1234);
        repeat (3) @(negedge clk);
        rd(2'd0, d);
        chk("R5 second value dropped", d, 32'h1234);
        load(16'h5678);
        rd(2'd0, d);
        chk("R5 later write accepted", d, 32'h5678);
    endtask

    task automatic t_hold();
        logic [31:0] d;
        load(16'h0100);
        repeat (20) @(negedge clk);
        rd(2'd0, d);
        chk("R6 stopped count holds", d, 32'h0100);
    endtask

    task automatic t_presc();
        logic [31:0] d;
        for (int c = 0; c < 8; c++) begin
            int dv;
            dv = div_of(c);
            load(16'h0000);
            wr(2'd1, KC | 32'h80 | 32'(c));
            repeat (2 * dv - 1) @(posedge clk);
            @(negedge clk);
            rd(2'd0, d);
            chk($sformatf("R7 code %0d before 2nd tick", c), d, 32'd1);
            @(negedge clk);
            rd(2'd0, d);
            chk($sformatf("R7 code %0d at 2nd tick", c), d, 32'd2);
            wr(2'd1, KC | 32'(c));
        end
    endtask

    task automatic t_ovf();
        logic [31:0] d;
        load(16'hFFFE);
        wr(2'd1, KC | 32'h80);
        rd(2'd0, d);
        chk("R8 start value", d, 32'hFFFE);
        @(negedge clk);
        rd(2'd0, d);
        chk("R8 top value", d, 32'hFFFF);
        chk("R8 no early pulse", 32'(rst_req), 32'd0);
        @(negedge clk);
        rd(2'd0, d);
        chk("R8 wrapped to zero", d, 32'h0);
        chk("R8 pulse high", 32'(rst_req), 32'd1);
        rd(2'd1, d);
        chk("R8 flag set", d, 32'h90);
        @(negedge clk);
        chk("R8 pulse one cycle", 32'(rst_req), 32'd0);
        wr(2'd1, KC | 32'h10);
        rd(2'd1, d);
        chk("R9 write 1 keeps flag", d, 32'h10);
        wr(2'd1, 32'h00000000);
        rd(2'd1, d);
        chk("R9 bad key keeps flag", d, 32'h10);
        wr(2'd1, KC);
        rd(2'd1, d);
        chk("R9 valid clear", d, 32'h0);
    endtask

    task automatic t_aux();
        logic [31:0] d;
        wr(2'd2, KC | 32'h3C);
        rd(2'd2, d);
        chk("R10 aux stored", d, 32'h3C);
        wr(2'd2, 32'h11223344);
        rd(2'd2, d);
        chk("R10 aux bad key", d, 32'h3C);
        load(16'h0000);
        wr(2'd1, KC | 32'h80);
        wr(2'd2, KC | 32'hC3);
        rd(2'd0, d);
        chk("R10 count during aux write", d, 32'd1);
        repeat (5) @(negedge clk);
        rd(2'd0, d);
        chk("R10 counting unaffected", d, 32'd6);
        rd(2'd2, d);
        chk("R10 aux updated", d, 32'hC3);
        wr(2'd1, KC);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_key();
        t_cnt_key();
        t_drop();
        t_hold();
        t_presc();
        t_ovf();
        t_aux();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule